// File: doc/BRIEF.md
# Bit-Oriented Code Receive Detector

This block sits on the receive side of a facility data link and looks for short repeating messages carried in the serial bit stream. Each message word is sixteen bits long: a flag of eight ones, a zero, six code bits sent least significant bit first, and a closing zero. The block recognises each well-formed word and counts how many identical words arrive back to back. Once that count reaches a programmable threshold, it publishes the six-bit code in a message register and raises an event so the host can read it.

Three sticky events are kept. The first is a change of state, set when a newly accepted code differs from the one already published. The second is an abort, set when eight consecutive ones arrive. The third is a message-cleared event, set when thirty link bits pass without a run of eight ones. The message-cleared event also returns the published code to all ones. Each event has its own mask bit toward a single interrupt line, and the host clears the events with a read-clear pulse. Software can restart the detector through an enable and through the rising edge of a reset-request bit.

Top module: `boc_rx_detector`

## Requirements
- R1: While `det_en` is 1, `msg_reg[5:0]` shows the published code and `msg_reg[7:6]` reads 0.
- R2: The published code is 6'h3F after `rst_n`, during every cycle with `det_en` at 0, and after a detector clear. While `det_en` is 0, incoming bits are ignored and no events are raised.
- R3: A word is recognised on the clock edge that samples its closing bit. The sixteen bits are, in arrival order: eight ones, a 0, code bits 0 to 5, and a 0. The consecutive count grows only when a word begins on the bit right after the previous word ended and carries the same code. Any other word restarts the count at 1, and a malformed word is never recognised.
- R4: The value of `filt_sel` sets how many consecutive identical words are needed: 2'b00 needs 1, 2'b01 needs 3, 2'b10 needs 5 and 2'b11 needs 7. The code is published on the edge that samples the closing bit of the word that reaches this count.
- R5: `evt_stat[0]` (change of state) is set when a code is published that differs from the code shown. Accepting a code equal to the one shown changes nothing.
- R6: A 0-to-1 change of `soft_rst` clears the detector for one cycle. Keeping `soft_rst` high has no further effect.
- R7: `evt_stat[1]` (abort) is set on the bit that completes a run of eight consecutive ones. It is set once per run.
- R8: `evt_stat[2]` (message cleared) is set when thirty bits have passed since the detector was cleared or since a run of eight or more ones last ended, with no such run in between. On that edge the published code becomes 6'h3F.
- R9: The bits of `evt_stat` stay set until a cycle with `stat_rd_clr` high clears them. An event raised in that same cycle stays set.
- R10: `irq` is high exactly when some `evt_stat[i]` and `evt_mask[i]` are both 1, with the same bit positions as `evt_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Received data link bit |
| det_en | input | 1 | Detector enable |
| soft_rst | input | 1 | Reset request, acts on its rising edge |
| filt_sel | input | 2 | Consecutive-word threshold select |
| evt_mask | input | 3 | Interrupt enables: bit0 change of state, bit1 abort, bit2 message cleared |
| stat_rd_clr | input | 1 | Read-clear pulse for the event bits |
| msg_reg | output | 8 | Published code in bits 5:0, zeros above |
| evt_stat | output | 3 | Sticky events, same order as `evt_mask` |
| irq | output | 1 | Masked interrupt |

## Verification
The collision that matters here is a read-clear pulse landing on the same edge that raises a new event. The bench drives `stat_rd_clr` together with the closing bit of a word that publishes a new code. It then expects the change-of-state bit to survive while the older abort bit from that word's flag is wiped. The behavioural model in the bench applies the same set-wins rule on every clock, so any other meeting of a clear and an event, such as a message-cleared event, is judged against the model in that cycle.

// File: rtl/boc_rx_pkg.sv
package boc_rx_pkg;
  localparam int CODE_W    = 6;
  localparam int FLAG_ONES = 8;
  localparam int CLR_BITS  = 30;
  localparam int MAX_RUN   = 7;
  localparam int MSG_W     = 8;
  localparam int EVT_N     = 3;
  localparam int EV_COS    = 0;
  localparam int EV_ABORT  = 1;
  localparam int EV_CLEAR  = 2;
endpackage

// File: rtl/boc_frame_shift.sv
module boc_frame_shift #(
  parameter int CODE_W    = boc_rx_pkg::CODE_W,
  parameter int FLAG_ONES = boc_rx_pkg::FLAG_ONES,
  parameter int CLR_BITS  = boc_rx_pkg::CLR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclr,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              word_ok,
  output logic [CODE_W-1:0] code,
  output logic              abort_pulse,
  output logic              clr_pulse
);
  localparam int WIN    = FLAG_ONES + CODE_W + 2;
  localparam int ONES_W = $clog2(FLAG_ONES + 1);
  localparam int CLR_W  = $clog2(CLR_BITS + 1);

  logic [WIN-2:0]    win_q, win_d;
  logic [WIN-1:0]    win_shift;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic [CLR_W-1:0]  clr_q, clr_d;
  logic              run_long;

  assign win_shift = {bit_in, win_q};
  assign code      = win_shift[WIN-2:FLAG_ONES+1];
  assign word_ok   = bit_vld & ~sclr & (&win_shift[FLAG_ONES-1:0])
                   & ~win_shift[FLAG_ONES] & ~win_shift[WIN-1];
  assign run_long  = bit_in & (ones_q >= ONES_W'(FLAG_ONES - 1));
  assign abort_pulse = bit_vld & ~sclr & bit_in & (ones_q == ONES_W'(FLAG_ONES - 1));
  assign clr_pulse   = bit_vld & ~sclr & ~run_long & (clr_q == CLR_W'(CLR_BITS - 1));

  always_comb begin
    win_d  = win_q;
    ones_d = ones_q;
    clr_d  = clr_q;
    if (sclr) begin
      win_d  = '0;
      ones_d = '0;
      clr_d  = '0;
    end else if (bit_vld) begin
      win_d = win_shift[WIN-1:1];
      if (!bit_in)
        ones_d = '0;
      else if (ones_q != ONES_W'(FLAG_ONES))
        ones_d = ones_q + ONES_W'(1);
      if (run_long)
        clr_d = '0;
      else if (clr_q != CLR_W'(CLR_BITS))
        clr_d = clr_q + CLR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      ones_q <= '0;
      clr_q  <= '0;
    end else begin
      win_q  <= win_d;
      ones_q <= ones_d;
      clr_q  <= clr_d;
    end
  end

  AST_CLEAR_NOT_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> !word_ok); // R8
endmodule

// File: rtl/boc_code_filter.sv
module boc_code_filter #(
  parameter int CODE_W  = boc_rx_pkg::CODE_W,
  parameter int WIN     = boc_rx_pkg::FLAG_ONES + boc_rx_pkg::CODE_W + 2,
  parameter int MAX_RUN = boc_rx_pkg::MAX_RUN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclr,
  input  logic              bit_vld,
  input  logic              word_ok,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        filt_sel,
  input  logic              clr_evt,
  output logic [CODE_W-1:0] rep_code,
  output logic              cos_pulse
);
  localparam int GAP_W = $clog2(WIN + 1);
  localparam int RUN_W = $clog2(MAX_RUN + 1);

  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [RUN_W-1:0]  run_q, run_d, run_new, need;
  logic [CODE_W-1:0] last_q, last_d, rep_q, rep_d;
  logic              chain;

  assign need    = (filt_sel == 2'b00) ? RUN_W'(1) : RUN_W'(2 * int'(filt_sel) + 1);
  assign chain   = (gap_q == GAP_W'(WIN - 1)) && (code == last_q);
  assign run_new = !chain ? RUN_W'(1)
                 : (run_q == RUN_W'(MAX_RUN)) ? run_q : run_q + RUN_W'(1);
  assign cos_pulse = word_ok & ~sclr & (run_new >= need) & (code != rep_q);
  assign rep_code  = rep_q;

  always_comb begin
    gap_d  = gap_q;
    run_d  = run_q;
    last_d = last_q;
    rep_d  = rep_q;
    if (sclr) begin
      gap_d  = GAP_W'(WIN);
      run_d  = '0;
      last_d = '1;
      rep_d  = '1;
    end else begin
      if (word_ok) begin
        gap_d  = '0;
        run_d  = run_new;
        last_d = code;
      end else if (bit_vld && gap_q != GAP_W'(WIN)) begin
        gap_d = gap_q + GAP_W'(1);
      end
      if (cos_pulse)
        rep_d = code;
      if (clr_evt)
        rep_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_W'(WIN);
      run_q  <= '0;
      last_q <= '1;
      rep_q  <= '1;
    end else begin
      gap_q  <= gap_d;
      run_q  <= run_d;
      last_q <= last_d;
      rep_q  <= rep_d;
    end
  end

  AST_CLEAR_GIVES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> (rep_q == '1)); // R2
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cos_pulse && !clr_evt && !sclr) |=> $stable(rep_q)); // R5
  AST_COS_MOVES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cos_pulse |=> (rep_q != $past(rep_q))); // R5
endmodule

// File: rtl/boc_evt_latch.sv
module boc_evt_latch #(
  parameter int EVT_N = boc_rx_pkg::EVT_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] set_vec,
  input  logic             rd_clr,
  input  logic [EVT_N-1:0] mask,
  output logic [EVT_N-1:0] stat,
  output logic             irq
);
  logic [EVT_N-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (rd_clr)
      stat_d = '0;
    stat_d = stat_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & mask);

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R9
endmodule

// File: rtl/boc_rx_detector.sv
module boc_rx_detector #(
  parameter int CODE_W    = boc_rx_pkg::CODE_W,
  parameter int FLAG_ONES = boc_rx_pkg::FLAG_ONES,
  parameter int CLR_BITS  = boc_rx_pkg::CLR_BITS,
  parameter int MAX_RUN   = boc_rx_pkg::MAX_RUN,
  parameter int MSG_W     = boc_rx_pkg::MSG_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_vld,
  input  logic                         bit_in,
  input  logic                         det_en,
  input  logic                         soft_rst,
  input  logic [1:0]                   filt_sel,
  input  logic [boc_rx_pkg::EVT_N-1:0] evt_mask,
  input  logic                         stat_rd_clr,
  output logic [MSG_W-1:0]             msg_reg,
  output logic [boc_rx_pkg::EVT_N-1:0] evt_stat,
  output logic                         irq
);
  localparam int WIN = FLAG_ONES + CODE_W + 2;

  logic                         soft_q;
  logic                         sclr;
  logic                         word_ok, abort_pulse, clr_pulse, cos_pulse;
  logic [CODE_W-1:0]            code, rep_code;
  logic [boc_rx_pkg::EVT_N-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= soft_rst;
  end

  assign sclr = ~det_en | (soft_rst & ~soft_q);

  boc_frame_shift #(.CODE_W(CODE_W), .FLAG_ONES(FLAG_ONES), .CLR_BITS(CLR_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .bit_vld(bit_vld), .bit_in(bit_in),
    .word_ok(word_ok), .code(code), .abort_pulse(abort_pulse), .clr_pulse(clr_pulse)
  );

  boc_code_filter #(.CODE_W(CODE_W), .WIN(WIN), .MAX_RUN(MAX_RUN)) u_filter (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .bit_vld(bit_vld), .word_ok(word_ok),
    .code(code), .filt_sel(filt_sel), .clr_evt(clr_pulse),
    .rep_code(rep_code), .cos_pulse(cos_pulse)
  );

  always_comb begin
    set_vec = '0;
    set_vec[boc_rx_pkg::EV_COS]   = cos_pulse;
    set_vec[boc_rx_pkg::EV_ABORT] = abort_pulse;
    set_vec[boc_rx_pkg::EV_CLEAR] = clr_pulse;
  end

  boc_evt_latch #(.EVT_N(boc_rx_pkg::EVT_N)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(stat_rd_clr),
    .mask(evt_mask), .stat(evt_stat), .irq(irq)
  );

  assign msg_reg = {{(MSG_W-CODE_W){1'b0}}, rep_code};
endmodule

// File: tb/tb_boc_rx_detector.sv
`timescale 1ns/1ps
module tb_boc_rx_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0, bit_in = 1'b0, det_en = 1'b0, soft_rst = 1'b0;
  logic [1:0] filt_sel = 2'b00;
  logic [2:0] evt_mask = 3'b000;
  logic       stat_rd_clr = 1'b0;
  logic [7:0] msg_reg;
  logic [2:0] evt_stat;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  boc_rx_detector dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .det_en(det_en),
    .soft_rst(soft_rst), .filt_sel(filt_sel), .evt_mask(evt_mask),
    .stat_rd_clr(stat_rd_clr), .msg_reg(msg_reg), .evt_stat(evt_stat), .irq(irq)
  );

  // behavioural reference
  bit   hist[$];
  int   m_ones, m_since, m_gap, m_run, m_need;
  bit [5:0] m_last, m_rep, m_code;
  bit [2:0] m_stat, m_set;
  bit   m_soft_prev, m_clear, m_word;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    hist.delete();
    m_ones = 0; m_since = 0; m_gap = 1000; m_run = 0;
    m_last = 6'h3F; m_rep = 6'h3F;
  endtask

  initial begin
    model_clear();
    m_stat = 0; m_soft_prev = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      m_stat = 0; m_soft_prev = 0;
    end else begin
      m_set = 0;
      m_clear = !det_en || (soft_rst && !m_soft_prev);
      m_soft_prev = soft_rst;
      if (m_clear) begin
        model_clear();
      end else if (bit_vld) begin
        hist.push_back(bit_in);
        if (hist.size() > 16) void'(hist.pop_front());
        m_ones = bit_in ? m_ones + 1 : 0;
        if (m_ones == 8) m_set[1] = 1;
        if (m_ones >= 8) m_since = 0;
        else begin
          m_since++;
          if (m_since == 30) begin m_set[2] = 1; m_rep = 6'h3F; end
        end
        m_word = (hist.size() == 16) && (hist[8] == 0) && (hist[15] == 0);
        for (int i = 0; i < 8; i++) if (hist.size() == 16 && hist[i] == 0) m_word = 0;
        if (m_word) begin
          for (int i = 0; i < 6; i++) m_code[i] = hist[9 + i];
          m_run = (m_gap == 15 && m_code == m_last) ? m_run + 1 : 1;
          m_last = m_code;
          m_gap = 0;
          m_need = (filt_sel == 0) ? 1 : 2 * filt_sel + 1;
          if (m_run >= m_need && m_code != m_rep) begin m_rep = m_code; m_set[0] = 1; end
        end else m_gap++;
      end
      if (stat_rd_clr) m_stat = 0;
      m_stat = m_stat | m_set;
      #1;
      check("R1 msg_reg", msg_reg, {2'b00, m_rep});
      check("R5 change-of-state bit", evt_stat[0], m_stat[0]);
      check("R7 abort bit", evt_stat[1], m_stat[1]);
      check("R8 cleared bit", evt_stat[2], m_stat[2]);
      check("R10 irq", irq, |(m_stat & evt_mask));
    end
  end

  task automatic send_bit(bit b, bit rc = 0);
    @(negedge clk); bit_vld = 1; bit_in = b; stat_rd_clr = rc;
    @(negedge clk); bit_vld = 0; stat_rd_clr = 0;
  endtask

  task automatic send_word(bit [5:0] c, bit bad = 0, bit rc_last = 0);
    for (int i = 0; i < 8; i++) send_bit(1);
    send_bit(0);
    for (int i = 0; i < 6; i++) send_bit(c[i]);
    send_bit(bad, rc_last);
  endtask

  task automatic read_clear();
    @(negedge clk); stat_rd_clr = 1;
    @(negedge clk); stat_rd_clr = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset msg", msg_reg, 8'h3F);
    check("R9 reset stat", evt_stat, 0);
    check("R10 reset irq", irq, 0);

    det_en = 1; evt_mask = 3'b111; filt_sel = 2'b00;
    send_word(6'h12);
    check("R4 filter 00 accept", msg_reg, 8'h12);
    check("R5 cos set", evt_stat[0], 1);
    check("R7 abort from flag", evt_stat[1], 1);
    read_clear();

    filt_sel = 2'b01;
    send_word(6'h2A); send_word(6'h2A);
    check("R4 filter 01 not yet", msg_reg, 8'h12);
    send_word(6'h2A);
    check("R4 filter 01 third word", msg_reg, 8'h2A);

    filt_sel = 2'b10;
    repeat (4) send_word(6'h05);
    send_word(6'h05, 1);
    repeat (4) send_word(6'h05);
    check("R3 broken run restarts", msg_reg, 8'h2A);
    send_word(6'h05);
    check("R3 five after break", msg_reg, 8'h05);
    read_clear();
    send_word(6'h05);
    check("R5 same code no event", evt_stat[0], 0);

    repeat (30) send_bit(0);
    check("R8 cleared event", evt_stat[2], 1);
    check("R8 code back to ones", msg_reg, 8'h3F);

    filt_sel = 2'b11;
    read_clear();
    repeat (6) send_word(6'h1B);
    check("R4 filter 11 six words", msg_reg, 8'h3F);
    send_word(6'h1B);
    check("R4 filter 11 seventh", msg_reg, 8'h1B);

    filt_sel = 2'b00;
    read_clear();
    send_word(6'h21, 0, 1);
    check("R9 set wins over read-clear", evt_stat, 3'b001);
    check("R1 upper bits zero", msg_reg[7:6], 0);

    @(negedge clk); soft_rst = 1;
    @(negedge clk); @(negedge clk);
    check("R6 edge clears code", msg_reg, 8'h3F);
    send_word(6'h0C);
    check("R6 held high no effect", msg_reg, 8'h0C);
    @(negedge clk); soft_rst = 0;
    @(negedge clk); soft_rst = 1;
    @(negedge clk);
    check("R6 second edge clears", msg_reg, 8'h3F);
    soft_rst = 0;

    @(negedge clk); evt_mask = 3'b000;
    @(negedge clk);
    check("R10 all masked", irq, 0);
    evt_mask = 3'b001;
    @(negedge clk);
    check("R10 cos unmasked", irq, evt_stat[0]);

    read_clear();
    det_en = 0;
    send_word(6'h11);
    check("R2 disabled ignores word", msg_reg, 8'h3F);
    check("R2 disabled no events", evt_stat, 0);
    det_en = 1;
    send_word(6'h11);
    check("R2 re-enabled accepts", msg_reg, 8'h11);

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule